// File: doc/BRIEF.md
# Pseudo-Von Neumann Address Mapper

This block turns the two logical addresses a small 16-bit core issues each cycle into physical memory selects and physical word offsets. One address is the instruction-fetch address. The other is the data-pointer address. The targets are four 16k-word program flash pages (P0 to P3), a utility ROM and a data SRAM. The mapper is purely combinational. It sits between the core's address generators and the memory arrays, and the core sees the result in the same cycle.

Two controls shape the program-space map. The lower 32k words always reach P0/P1. A single upper-execution bit either hands 8000h–FFFFh to P2/P3, or leaves the utility ROM at 8000h and a window into the data SRAM at A000h. The data-space map depends on three things: which segment is executing, the byte/word access mode, and a two-bit page-select field. The segment that is executing never appears in data space. Any data or fetch access that falls outside every mapped window raises an error flag. In that case no select is driven and all address and lane outputs read zero.

Top module: `pvn_addr_mapper`

## Requirements
- R1: A fetch address below 8000h selects P0 when bit 14 is 0 and P1 when bit 14 is 1. The physical word is bits 13:0 of the address. The upper-execution bit has no effect on this.
- R2: With upper-execution 0, fetches from 8000h up to 8000h + ROM size − 1 select the ROM at offset (address − 8000h). Fetches from A000h up to A000h + SRAM size − 1 select the SRAM at offset (address − A000h). Any other fetch at or above 8000h raises the fetch error with no select and word 0000h.
- R3: With upper-execution 1, fetches from 8000h to BFFFh select P2 and fetches from C000h to FFFFh select P3, at offset bits 13:0. The ROM and the SRAM are never selected for a fetch in this case.
- R4: Executing-segment code 0 (user flash): data addresses with bit 15 clear map to the SRAM, and data addresses with bit 15 set map to the ROM.
- R5: Executing-segment code 1 (utility ROM): the lower data half maps to the SRAM and the upper data half maps to program pages.
- R6: Executing-segment code 2 (data SRAM): the lower data half maps to program pages and the upper data half maps to the ROM.
- R7: Word mode (byte_mode_i = 0): the in-half offset is address bits 14:0 and lanes are 2'b11. For program pages, code_sel_i[1] picks the pair (P0/P1 or P2/P3), offset bit 14 picks the page within the pair, and the word is offset bits 13:0. code_sel_i[0] is ignored.
- R8: Byte mode: the in-half word offset is address bits 14:1, which is the byte address shifted right by one. For program pages, code_sel_i selects a single page (0 = P0 up to 3 = P3). Lanes are 2'b01 for an even byte and 2'b10 for an odd byte.
- R9: The executing segment is never selected as data. Executing-segment code 3 makes every data access illegal.
- R10: A data offset beyond the SRAM or ROM size raises the data error. Whenever data error is 1, the data select, word and lanes are all zero.
- R11: Select vectors use bit 0 = P0, bit 1 = P1, bit 2 = P2, bit 3 = P3, bit 4 = ROM and bit 5 = SRAM. At most one bit is set, and the error flag is 1 exactly when no bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_addr_i | input | 16 | Logical program-fetch word address |
| data_addr_i | input | 16 | Logical data address (word or byte granular) |
| byte_mode_i | input | 1 | 1 = byte-granular data access, 0 = word |
| upper_exec_i | input | 1 | 1 = P2/P3 executable in the upper program half |
| code_sel_i | input | 2 | Program page selection for data-space access |
| exec_seg_i | input | 2 | Executing segment: 0 flash, 1 ROM, 2 SRAM, 3 reserved |
| fetch_sel_o | output | 6 | One-hot fetch target select |
| fetch_word_o | output | 16 | Physical word offset in the fetch target |
| fetch_err_o | output | 1 | Fetch address hits no mapped window |
| data_sel_o | output | 6 | One-hot data target select |
| data_word_o | output | 16 | Physical word offset in the data target |
| data_lane_o | output | 2 | Byte lane enables (bit 0 low byte, bit 1 high byte) |
| data_err_o | output | 1 | Illegal or unmapped data access |

## Verification
The embedded assertions guard the structural invariants on every evaluation. These are: at most one select is set, and the error flag agrees with it. An error always comes with zero address and lanes. The executing segment never shows up among the data selects. The ROM and SRAM stay unreachable for fetch once upper execution is on. Byte mode enables exactly one lane. What those checks cannot show is that each address lands on the right page and offset. That is covered by the bench's directed scenarios, which walk window edges, page-pair selection, the ignored low page bit in word mode, byte shifting and lane choice, and the reserved segment code, and compare against hand-computed values.

// File: rtl/pvn_pkg.sv
package pvn_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned N_TGT  = 6;

  localparam int unsigned TGT_P0   = 0;
  localparam int unsigned TGT_P1   = 1;
  localparam int unsigned TGT_P2   = 2;
  localparam int unsigned TGT_P3   = 3;
  localparam int unsigned TGT_ROM  = 4;
  localparam int unsigned TGT_SRAM = 5;

  typedef logic [N_TGT-1:0]  tgt_sel_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    SEG_FLASH = 2'd0,
    SEG_UROM  = 2'd1,
    SEG_SRAM  = 2'd2,
    SEG_RSVD  = 2'd3
  } exec_seg_e;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_PAGES,
    RGN_ROM,
    RGN_SRAM
  } region_e;
endpackage

// File: rtl/pvn_window.sv
module pvn_window
  import pvn_pkg::*;
#(
  parameter addr_t       BASE = '0,
  parameter int unsigned AW   = 8
) (
  input  addr_t addr_i,
  output logic  hit_o,
  output addr_t off_o
);
  addr_t rel;

  always_comb begin
    rel   = addr_i - BASE;
    hit_o = (rel >> AW) == '0;
    off_o = hit_o ? rel : '0;
  end
endmodule

// File: rtl/pvn_fetch_map.sv
module pvn_fetch_map
  import pvn_pkg::*;
#(
  parameter int unsigned ROM_AW    = 12,
  parameter int unsigned SRAM_AW   = 8,
  parameter addr_t       SRAM_BASE = 16'hA000
) (
  input  addr_t    addr_i,
  input  logic     upper_exec_i,
  output tgt_sel_t sel_o,
  output addr_t    word_o,
  output logic     err_o
);
  localparam addr_t ROM_BASE = 16'h8000;

  logic  rom_hit, sram_hit;
  addr_t rom_off, sram_off;

  pvn_window #(.BASE(ROM_BASE), .AW(ROM_AW)) u_rom_win (
    .addr_i(addr_i), .hit_o(rom_hit), .off_o(rom_off)
  );
  pvn_window #(.BASE(SRAM_BASE), .AW(SRAM_AW)) u_sram_win (
    .addr_i(addr_i), .hit_o(sram_hit), .off_o(sram_off)
  );

  always_comb begin
    sel_o  = '0;
    word_o = '0;
    err_o  = 1'b0;
    if (!addr_i[15]) begin
      sel_o[addr_i[14] ? TGT_P1 : TGT_P0] = 1'b1;
      word_o = {2'b00, addr_i[13:0]};
    end else if (upper_exec_i) begin
      sel_o[addr_i[14] ? TGT_P3 : TGT_P2] = 1'b1;
      word_o = {2'b00, addr_i[13:0]};
    end else if (rom_hit) begin
      sel_o[TGT_ROM] = 1'b1;
      word_o = rom_off;
    end else if (sram_hit) begin
      sel_o[TGT_SRAM] = 1'b1;
      word_o = sram_off;
    end else begin
      err_o = 1'b1;
    end
  end

  always_comb begin
    a_r11_fetch_onehot: assert ($onehot0(sel_o) && (err_o == (sel_o == '0)))
      else $error("fetch select not one-hot or error flag mismatch");
    a_r2_fetch_err_quiet: assert (!err_o || word_o == '0)
      else $error("fetch error with nonzero word");
    a_r3_upper_no_rom_sram: assert (!upper_exec_i || !(sel_o[TGT_ROM] || sel_o[TGT_SRAM]))
      else $error("ROM/SRAM fetched with upper execution on");
    a_r1_low_half_flash: assert (addr_i[15] || (sel_o[TGT_P0] || sel_o[TGT_P1]))
      else $error("low fetch half not on P0/P1");
  end
endmodule

// File: rtl/pvn_data_map.sv
module pvn_data_map
  import pvn_pkg::*;
#(
  parameter int unsigned ROM_AW  = 12,
  parameter int unsigned SRAM_AW = 8
) (
  input  addr_t     addr_i,
  input  logic      byte_mode_i,
  input  logic [1:0] code_sel_i,
  input  exec_seg_e exec_seg_i,
  output tgt_sel_t  sel_o,
  output addr_t     word_o,
  output logic [1:0] lane_o,
  output logic      err_o
);
  addr_t     off;
  region_e   rgn;
  logic      rom_hit, sram_hit;
  addr_t     rom_off, sram_off;
  logic [1:0] page;

  // offset inside the selected half, in words
  assign off = byte_mode_i ? {2'b00, addr_i[14:1]} : {1'b0, addr_i[14:0]};

  pvn_window #(.BASE('0), .AW(ROM_AW)) u_rom_win (
    .addr_i(off), .hit_o(rom_hit), .off_o(rom_off)
  );
  pvn_window #(.BASE('0), .AW(SRAM_AW)) u_sram_win (
    .addr_i(off), .hit_o(sram_hit), .off_o(sram_off)
  );

  always_comb begin
    unique case (exec_seg_i)
      SEG_FLASH: rgn = addr_i[15] ? RGN_ROM   : RGN_SRAM;
      SEG_UROM:  rgn = addr_i[15] ? RGN_PAGES : RGN_SRAM;
      SEG_SRAM:  rgn = addr_i[15] ? RGN_ROM   : RGN_PAGES;
      default:   rgn = RGN_NONE;
    endcase
  end

  assign page = byte_mode_i ? code_sel_i : {code_sel_i[1], off[14]};

  always_comb begin
    sel_o  = '0;
    word_o = '0;
    lane_o = '0;
    err_o  = 1'b0;
    unique case (rgn)
      RGN_PAGES: begin
        sel_o[TGT_P0 + int'(page)] = 1'b1;
        word_o = {2'b00, off[13:0]};
      end
      RGN_ROM: begin
        sel_o[TGT_ROM] = rom_hit;
        word_o = rom_off;
        err_o  = !rom_hit;
      end
      RGN_SRAM: begin
        sel_o[TGT_SRAM] = sram_hit;
        word_o = sram_off;
        err_o  = !sram_hit;
      end
      default: err_o = 1'b1;
    endcase
    if (!err_o) lane_o = byte_mode_i ? (addr_i[0] ? 2'b10 : 2'b01) : 2'b11;
  end

  always_comb begin
    a_r11_data_onehot: assert ($onehot0(sel_o) && (err_o == (sel_o == '0)))
      else $error("data select not one-hot or error flag mismatch");
    a_r10_err_quiet: assert (!err_o || (word_o == '0 && lane_o == '0))
      else $error("data error with live address or lanes");
    a_r9_no_self_rom: assert (!(exec_seg_i == SEG_UROM && sel_o[TGT_ROM]))
      else $error("executing ROM selected as data");
    a_r9_no_self_sram: assert (!(exec_seg_i == SEG_SRAM && sel_o[TGT_SRAM]))
      else $error("executing SRAM selected as data");
    a_r4_no_pages_from_flash: assert (!(exec_seg_i == SEG_FLASH && (sel_o[3:0] != '0)))
      else $error("program page selected as data while executing flash");
    a_r8_byte_one_lane: assert (!byte_mode_i || err_o || $countones(lane_o) == 1)
      else $error("byte access enables other than one lane");
  end
endmodule

// File: rtl/pvn_addr_mapper.sv
module pvn_addr_mapper
  import pvn_pkg::*;
#(
  parameter int unsigned ROM_AW    = 12,
  parameter int unsigned SRAM_AW   = 8,
  parameter logic [15:0] SRAM_BASE = 16'hA000
) (
  input  logic [15:0] fetch_addr_i,
  input  logic [15:0] data_addr_i,
  input  logic        byte_mode_i,
  input  logic        upper_exec_i,
  input  logic [1:0]  code_sel_i,
  input  logic [1:0]  exec_seg_i,
  output logic [5:0]  fetch_sel_o,
  output logic [15:0] fetch_word_o,
  output logic        fetch_err_o,
  output logic [5:0]  data_sel_o,
  output logic [15:0] data_word_o,
  output logic [1:0]  data_lane_o,
  output logic        data_err_o
);
  exec_seg_e seg;
  assign seg = exec_seg_e'(exec_seg_i);

  pvn_fetch_map #(
    .ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW), .SRAM_BASE(SRAM_BASE)
  ) u_fetch (
    .addr_i      (fetch_addr_i),
    .upper_exec_i(upper_exec_i),
    .sel_o       (fetch_sel_o),
    .word_o      (fetch_word_o),
    .err_o       (fetch_err_o)
  );

  pvn_data_map #(
    .ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW)
  ) u_data (
    .addr_i     (data_addr_i),
    .byte_mode_i(byte_mode_i),
    .code_sel_i (code_sel_i),
    .exec_seg_i (seg),
    .sel_o      (data_sel_o),
    .word_o     (data_word_o),
    .lane_o     (data_lane_o),
    .err_o      (data_err_o)
  );
endmodule

// File: tb/pvn_addr_mapper_bench.sv
module pvn_addr_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] S_P0 = 6'h01, S_P1 = 6'h02, S_P2 = 6'h04, S_P3 = 6'h08,
                         S_ROM = 6'h10, S_SRAM = 6'h20, S_NONE = 6'h00;

  logic        clk = 1'b0;
  logic [15:0] fetch_addr, data_addr;
  logic        byte_mode, upper_exec;
  logic [1:0]  code_sel, exec_seg;
  logic [5:0]  fetch_sel, data_sel;
  logic [15:0] fetch_word, data_word;
  logic        fetch_err, data_err;
  logic [1:0]  data_lane;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvn_addr_mapper u_pvn_addr_mapper (
    .fetch_addr_i(fetch_addr), .data_addr_i(data_addr), .byte_mode_i(byte_mode),
    .upper_exec_i(upper_exec), .code_sel_i(code_sel), .exec_seg_i(exec_seg),
    .fetch_sel_o(fetch_sel), .fetch_word_o(fetch_word), .fetch_err_o(fetch_err),
    .data_sel_o(data_sel), .data_word_o(data_word), .data_lane_o(data_lane),
    .data_err_o(data_err)
  );

  task automatic cmp(input string req, input string what, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic fetch_case(input string req, input logic [15:0] a, input logic upx,
                            input logic [5:0] es, input logic [15:0] ew, input logic ee);
    @(negedge clk);
    fetch_addr = a; upper_exec = upx;
    #1;
    cmp(req, "fetch_sel", {10'd0, fetch_sel}, {10'd0, es});
    cmp(req, "fetch_word", fetch_word, ew);
    cmp(req, "fetch_err", {15'd0, fetch_err}, {15'd0, ee});
  endtask

  task automatic data_case(input string req, input logic [1:0] sg, input logic bm,
                           input logic [1:0] cs, input logic [15:0] a,
                           input logic [5:0] es, input logic [15:0] ew,
                           input logic [1:0] el, input logic ee);
    @(negedge clk);
    exec_seg = sg; byte_mode = bm; code_sel = cs; data_addr = a;
    #1;
    cmp(req, "data_sel", {10'd0, data_sel}, {10'd0, es});
    cmp(req, "data_word", data_word, ew);
    cmp(req, "data_lane", {14'd0, data_lane}, {14'd0, el});
    cmp(req, "data_err", {15'd0, data_err}, {15'd0, ee});
  endtask

  task automatic t_idle;  // all-zero inputs: P0 fetch, SRAM data word 0
    fetch_case("R1", 16'h0000, 1'b0, S_P0, 16'h0000, 1'b0);
    data_case("R4", 2'd0, 1'b0, 2'd0, 16'h0000, S_SRAM, 16'h0000, 2'b11, 1'b0);
  endtask

  task automatic t_fetch_low;
    fetch_case("R1", 16'h1234, 1'b0, S_P0, 16'h1234, 1'b0);
    fetch_case("R1", 16'h5678, 1'b1, S_P1, 16'h1678, 1'b0);
    fetch_case("R1", 16'h7FFF, 1'b0, S_P1, 16'h3FFF, 1'b0);
  endtask

  task automatic t_fetch_rom_sram;
    fetch_case("R2", 16'h8ABC, 1'b0, S_ROM, 16'h0ABC, 1'b0);
    fetch_case("R2", 16'h8FFF, 1'b0, S_ROM, 16'h0FFF, 1'b0);
    fetch_case("R2", 16'h9000, 1'b0, S_NONE, 16'h0000, 1'b1);
    fetch_case("R2", 16'hA0FF, 1'b0, S_SRAM, 16'h00FF, 1'b0);
    fetch_case("R2", 16'hA100, 1'b0, S_NONE, 16'h0000, 1'b1);
  endtask

  task automatic t_fetch_upper;
    fetch_case("R3", 16'h8ABC, 1'b1, S_P2, 16'h0ABC, 1'b0);
    fetch_case("R3", 16'hA010, 1'b1, S_P2, 16'h2010, 1'b0);
    fetch_case("R3", 16'hFFFF, 1'b1, S_P3, 16'h3FFF, 1'b0);
  endtask

  task automatic t_data_flash;
    data_case("R4", 2'd0, 1'b0, 2'd0, 16'h0010, S_SRAM, 16'h0010, 2'b11, 1'b0);
    data_case("R4", 2'd0, 1'b0, 2'd3, 16'h8FFF, S_ROM, 16'h0FFF, 2'b11, 1'b0);
    data_case("R10", 2'd0, 1'b0, 2'd0, 16'h0100, S_NONE, 16'h0000, 2'b00, 1'b1);
    data_case("R10", 2'd0, 1'b0, 2'd0, 16'h9000, S_NONE, 16'h0000, 2'b00, 1'b1);
  endtask

  task automatic t_data_rom;
    data_case("R5", 2'd1, 1'b0, 2'd0, 16'h0020, S_SRAM, 16'h0020, 2'b11, 1'b0);
    data_case("R7", 2'd1, 1'b0, 2'd0, 16'hC123, S_P1, 16'h0123, 2'b11, 1'b0);
    data_case("R7", 2'd1, 1'b0, 2'd2, 16'h8005, S_P2, 16'h0005, 2'b11, 1'b0);
    data_case("R7", 2'd1, 1'b0, 2'd1, 16'h8005, S_P0, 16'h0005, 2'b11, 1'b0);
  endtask

  task automatic t_data_sram;
    data_case("R6", 2'd2, 1'b0, 2'd3, 16'h7FFF, S_P3, 16'h3FFF, 2'b11, 1'b0);
    data_case("R6", 2'd2, 1'b0, 2'd0, 16'h8100, S_ROM, 16'h0100, 2'b11, 1'b0);
  endtask

  task automatic t_byte_mode;
    data_case("R8", 2'd1, 1'b1, 2'd3, 16'h8007, S_P3, 16'h0003, 2'b10, 1'b0);
    data_case("R8", 2'd1, 1'b1, 2'd1, 16'hFFFE, S_P1, 16'h3FFF, 2'b01, 1'b0);
    data_case("R8", 2'd2, 1'b1, 2'd2, 16'h0003, S_P2, 16'h0001, 2'b10, 1'b0);
    data_case("R8", 2'd0, 1'b1, 2'd0, 16'h01FF, S_SRAM, 16'h00FF, 2'b10, 1'b0);
    data_case("R10", 2'd0, 1'b1, 2'd0, 16'h0200, S_NONE, 16'h0000, 2'b00, 1'b1);
    data_case("R8", 2'd0, 1'b1, 2'd0, 16'h9FFE, S_ROM, 16'h0FFF, 2'b01, 1'b0);
  endtask

  task automatic t_reserved;
    data_case("R9", 2'd3, 1'b0, 2'd0, 16'h0000, S_NONE, 16'h0000, 2'b00, 1'b1);
    data_case("R9", 2'd3, 1'b1, 2'd2, 16'h8004, S_NONE, 16'h0000, 2'b00, 1'b1);
  endtask

  initial begin
    fetch_addr = '0; data_addr = '0; byte_mode = 1'b0; upper_exec = 1'b0;
    code_sel = '0; exec_seg = '0;
    t_idle();
    t_fetch_low();
    t_fetch_rom_sram();
    t_fetch_upper();
    t_data_flash();
    t_data_rom();
    t_data_sram();
    t_byte_mode();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule